// File: doc/BRIEF.md
# Dual-Channel Serial Rate Divider

This block turns the system clock into two independent pairs of timing strobes for an asynchronous serial port, one pair for the transmit side and one for the receive side. Each pair is a one-cycle oversampling strobe at sixteen times the bit rate and a one-cycle bit strobe. The bit strobe fires on every sixteenth oversampling strobe and in the same cycle as that strobe. The framing and shift logic of the port consume these strobes.

The period of the oversampling strobe, in clock cycles, is the product of three factors. The first is a coarse prescale factor from a 2-bit code. This code is shared by both channels and picks one of four values, not all of them powers of two. The second is a per-channel power-of-two range factor from a 3-bit code. The third is a per-channel 8-bit fine factor, which is bypassed when it is zero. Each channel takes a snapshot of its settings while it is disabled and holds that snapshot while it is enabled. Software must set a channel's settings with the channel off and then turn it on.

Top module: `uart_baud_gen`

## Requirements
- R1: The shared 2-bit prescale code selects the factor 1 for code 0, 3 for code 1, 4 for code 2 and 13 for code 3. With the range code and the fine value at 0, the oversampling strobe repeats every factor clock cycles.
- R2: A channel's 3-bit range code n multiplies its strobe period by 2^n, for n from 0 to 7.
- R3: A non-zero 8-bit fine value f multiplies the channel's strobe period by f, so the period is prescale × 2^n × f cycles.
- R4: A fine value of 0 bypasses the fine stage, so the period is prescale × 2^n cycles.
- R5: The bit strobe is high only in the same cycle as an oversampling strobe, and only on every sixteenth oversampling strobe counted from enable.
- R6: While a channel's enable is low, both of its strobes stay low and its counters are cleared. Enable is sampled on the rising clock edge. The first oversampling strobe is visible after exactly one full period of edges at which enable is high.
- R7: Changes to the prescale code, range code or fine value while a channel is enabled have no effect on that channel. The new values take effect only after it has been disabled and enabled again.
- R8: The two channels run independently. Each has its own enable, range code and fine value, and they share only the prescale code.
- R9: With prescale code 3 and both other settings at 0, the bit period is 208 clock cycles. This gives about 38400 baud from an 8 MHz clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psc_code | input | 2 | Shared prescale code |
| tx_en | input | 1 | Transmit channel enable |
| tx_range | input | 3 | Transmit power-of-two range code |
| tx_fine | input | 8 | Transmit fine divider, 0 = bypass |
| rx_en | input | 1 | Receive channel enable |
| rx_range | input | 3 | Receive power-of-two range code |
| rx_fine | input | 8 | Receive fine divider, 0 = bypass |
| tx_tick16 | output | 1 | Transmit oversampling strobe |
| tx_bit_tick | output | 1 | Transmit bit strobe |
| rx_tick16 | output | 1 | Receive oversampling strobe |
| rx_bit_tick | output | 1 | Receive bit strobe |

## Verification
A wrongly decoded or wrongly latched setting shows up as a strobe period that differs from the expected product. It can be seen at the first oversampling strobe after enable, one period in. A broken sixteen-count shows up as a bit strobe that comes early, comes late or misses its oversampling strobe. It can be seen within sixteen periods. A counter that is not cleared, or a snapshot that is not frozen, shows up as a shortened first period after re-enable, or as a period that follows a write made while the channel is enabled.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
    localparam int PSC_W     = 2;
    localparam int RNG_W     = 3;
    localparam int EXT_W     = 8;
    localparam int PSC_VAL_W = 4;
    localparam int PROD_W    = PSC_VAL_W + EXT_W;
    localparam int DIV_W     = PROD_W + (1 << RNG_W) - 1;
    localparam int NCH       = 2;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [RNG_W-1:0] rng;
        logic [EXT_W-1:0] ext;
    } baud_cfg_t;

    function automatic logic [PSC_VAL_W-1:0] psc_value(input logic [PSC_W-1:0] code);
        logic [PSC_VAL_W-1:0] v;
        case (code)
            2'd0:    v = 4'd1;
            2'd1:    v = 4'd3;
            2'd2:    v = 4'd4;
            default: v = 4'd13;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/uart_baud_div_decode.sv
module uart_baud_div_decode
    import uart_baud_pkg::*;
(
    input  baud_cfg_t        cfg,
    output logic [DIV_W-1:0] div
);
    logic [PSC_VAL_W-1:0] pr;
    logic [EXT_W-1:0]     ext_eff;
    logic [PROD_W-1:0]    prod;

    always_comb begin
        pr      = psc_value(cfg.psc);
        ext_eff = (cfg.ext == '0) ? EXT_W'(1) : cfg.ext;
        prod    = PROD_W'(pr) * PROD_W'(ext_eff);
        div     = DIV_W'(prod) << cfg.rng;
    end
endmodule

// File: rtl/uart_baud_channel.sv
module uart_baud_channel
    import uart_baud_pkg::*;
#(
    parameter int SUB_N = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  baud_cfg_t cfg_in,
    output logic      tick16,
    output logic      bit_tick
);
    localparam int SUB_W = $clog2(SUB_N);

    typedef struct packed {
        baud_cfg_t        cfg;
        logic [DIV_W-1:0] cnt;
        logic [SUB_W-1:0] sub;
        logic             tick;
        logic             bit_tick;
    } chan_state_t;

    chan_state_t      s_d, s_q;
    logic [DIV_W-1:0] div;

    uart_baud_div_decode u_dec (
        .cfg (s_q.cfg),
        .div (div)
    );

    always_comb begin
        s_d          = s_q;
        s_d.tick     = 1'b0;
        s_d.bit_tick = 1'b0;
        if (!en) begin
            s_d.cfg = cfg_in;
            s_d.cnt = '0;
            s_d.sub = '0;
        end else if (s_q.cnt == div - DIV_W'(1)) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
            if (s_q.sub == SUB_W'(SUB_N - 1)) begin
                s_d.sub      = '0;
                s_d.bit_tick = 1'b1;
            end else begin
                s_d.sub = s_q.sub + SUB_W'(1);
            end
        end else begin
            s_d.cnt = s_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick16   = s_q.tick;
    assign bit_tick = s_q.bit_tick;

    // R6
    tick_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tick |-> $past(en));

    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(s_q.cfg));

    // R5
    bit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bit_tick |-> s_q.tick);

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < div);

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.tick && div != DIV_W'(1)) |=> !s_q.tick);
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc_code,
    input  logic             tx_en,
    input  logic [RNG_W-1:0] tx_range,
    input  logic [EXT_W-1:0] tx_fine,
    input  logic             rx_en,
    input  logic [RNG_W-1:0] rx_range,
    input  logic [EXT_W-1:0] rx_fine,
    output logic             tx_tick16,
    output logic             tx_bit_tick,
    output logic             rx_tick16,
    output logic             rx_bit_tick
);
    baud_cfg_t       cfg_arr [NCH];
    logic [NCH-1:0]  en_arr;
    logic [NCH-1:0]  tick_arr;
    logic [NCH-1:0]  bit_arr;

    assign cfg_arr[0] = '{psc: psc_code, rng: tx_range, ext: tx_fine};
    assign cfg_arr[1] = '{psc: psc_code, rng: rx_range, ext: rx_fine};
    assign en_arr     = {rx_en, tx_en};

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        uart_baud_channel #(.SUB_N(16)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_arr[g]),
            .cfg_in   (cfg_arr[g]),
            .tick16   (tick_arr[g]),
            .bit_tick (bit_arr[g])
        );
    end

    assign tx_tick16   = tick_arr[0];
    assign tx_bit_tick = bit_arr[0];
    assign rx_tick16   = tick_arr[1];
    assign rx_bit_tick = bit_arr[1];
endmodule

// File: tb/uart_baud_gen_test.sv
module uart_baud_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] psc_code = '0;
    logic       tx_en = 1'b0, rx_en = 1'b0;
    logic [2:0] tx_range = '0, rx_range = '0;
    logic [7:0] tx_fine = '0, rx_fine = '0;
    logic       tx_tick16, tx_bit_tick, rx_tick16, rx_bit_tick;
    int         checks = 0;
    int         failures = 0;

    always #5 clk = ~clk;

    uart_baud_gen uut (
        .clk(clk), .rst_n(rst_n), .psc_code(psc_code),
        .tx_en(tx_en), .tx_range(tx_range), .tx_fine(tx_fine),
        .rx_en(rx_en), .rx_range(rx_range), .rx_fine(rx_fine),
        .tx_tick16(tx_tick16), .tx_bit_tick(tx_bit_tick),
        .rx_tick16(rx_tick16), .rx_bit_tick(rx_bit_tick)
    );

    // columns: channel, prescale code, range code, fine value, expected period
    localparam int NV = 10;
    localparam int VEC [NV][5] = '{
        '{0, 0, 0, 0,   1},
        '{1, 1, 0, 0,   3},
        '{0, 2, 1, 0,   8},
        '{1, 3, 0, 0,  13},
        '{0, 0, 7, 0, 128},
        '{1, 1, 2, 0,  12},
        '{0, 0, 0, 1,   1},
        '{1, 3, 1, 5, 130},
        '{0, 2, 0, 255, 1020},
        '{1, 1, 1, 0,   6}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit tickv(input int ch);
        return (ch != 0) ? rx_tick16 : tx_tick16;
    endfunction

    function automatic bit bitv(input int ch);
        return (ch != 0) ? rx_bit_tick : tx_bit_tick;
    endfunction

    task automatic set_en(input int ch, input bit v);
        if (ch != 0) rx_en = v; else tx_en = v;
    endtask

    task automatic set_cfg(input int ch, input int p, input int r, input int e);
        psc_code = 2'(p);
        if (ch != 0) begin rx_range = 3'(r); rx_fine = 8'(e); end
        else         begin tx_range = 3'(r); tx_fine = 8'(e); end
    endtask

    task automatic wait_tick(input int ch, input int limit, output int n);
        n = 0;
        do begin
            @(posedge clk); @(negedge clk); n++;
        end while (!tickv(ch) && n < limit);
    endtask

    task automatic run_vec(input int ch, input int p, input int r, input int e,
                           input int exp, input string tag);
        int n, ticks, bit_at, bad_int, gap;
        bit stray;
        @(negedge clk);
        set_en(ch, 1'b0);
        set_cfg(ch, p, r, e);
        repeat (2) @(negedge clk);
        set_en(ch, 1'b1);
        wait_tick(ch, 4000, n);
        check(n == exp, tag, n, exp);
        ticks = 1; bit_at = 0; bad_int = 0; stray = 1'b0;
        if (bitv(ch)) bit_at = 1;
        while (ticks < 16) begin
            wait_tick(ch, 4000, gap);
            if (!tickv(ch)) begin bad_int = gap; ticks = 16; end
            else begin
                ticks++;
                if (gap != exp) bad_int = gap;
                if (bitv(ch) && bit_at == 0) bit_at = ticks;
            end
        end
        check(bad_int == 0, tag, bad_int, exp);
        check(bit_at == 16, "R5", bit_at, 16);
        @(negedge clk);
        set_en(ch, 1'b0);
        stray = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R6 watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, a, b;
        string tag;
        // reset state
        repeat (3) @(negedge clk);
        check({tx_tick16, tx_bit_tick, rx_tick16, rx_bit_tick} == 4'b0, "R6", 
              int'({tx_tick16, tx_bit_tick, rx_tick16, rx_bit_tick}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({tx_tick16, rx_tick16} == 2'b0, "R6", int'({tx_tick16, rx_tick16}), 0);

        // table walk: R1 prescale, R2 range, R3 fine, R4 bypass, R8 both channels
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][3] != 0)      tag = "R3";
            else if (i == NV - 1)    tag = "R4";
            else if (VEC[i][2] != 0) tag = "R2";
            else                     tag = "R1";
            run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], tag);
        end

        // R6: disable mid-count stops strobes and clears counters
        @(negedge clk);
        set_cfg(0, 0, 0, 5);
        repeat (2) @(negedge clk);
        tx_en = 1'b1;
        repeat (3) @(negedge clk);
        tx_en = 1'b0;
        a = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (tx_tick16 || tx_bit_tick) a++;
        end
        check(a == 0, "R6", a, 0);
        tx_en = 1'b1;
        wait_tick(0, 100, n);
        check(n == 5, "R6", n, 5);
        @(negedge clk); tx_en = 1'b0;

        // R7: writes while enabled ignored until re-enable
        @(negedge clk);
        set_cfg(0, 1, 0, 0);
        repeat (2) @(negedge clk);
        tx_en = 1'b1;
        wait_tick(0, 100, n);
        set_cfg(0, 2, 2, 0);
        wait_tick(0, 100, n);
        check(n == 3, "R7", n, 3);
        wait_tick(0, 100, n);
        check(n == 3, "R7", n, 3);
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        tx_en = 1'b1;
        wait_tick(0, 100, n);
        check(n == 16, "R7", n, 16);
        @(negedge clk); tx_en = 1'b0;

        // R8: channels concurrently with different fine values
        @(negedge clk);
        set_cfg(0, 0, 0, 3);
        set_cfg(1, 0, 0, 4);
        repeat (2) @(negedge clk);
        tx_en = 1'b1; rx_en = 1'b1;
        a = 0; b = 0;
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            if (tx_tick16) a++;
            if (rx_tick16) b++;
        end
        check(a == 40, "R8", a, 40);
        check(b == 30, "R8", b, 30);
        tx_en = 1'b0; rx_en = 1'b0;

        // R9: 208-cycle bit period
        @(negedge clk);
        set_cfg(1, 3, 0, 0);
        repeat (2) @(negedge clk);
        rx_en = 1'b1;
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!rx_bit_tick && n < 1000);
        check(n == 208, "R9", n, 208);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!rx_bit_tick && n < 1000);
        check(n == 208, "R9", n, 208);
        rx_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule